// File: doc/BRIEF.md
# In-Order Retirement Buffer with Out-of-Order Completion

This block sits between instruction decode and the architectural state of a pipelined core. Decode claims the next free slot of a circular buffer for each instruction, in program order, and receives a tag. Functional units later post results into that slot by tag, in whatever order they finish. A result may be a register value, a store address and data pair, or an exception flag.

Only the oldest slot may leave the buffer. If it has finished cleanly, it retires. A register result is written into the architectural register file, which the block holds. A store's address and data are presented on the retire port for the memory side to perform. If the oldest slot has finished with an exception, the block drops all in-flight work. It presents the faulting instruction's PC, redirects fetch to a fixed handler address, and the faulting result is never written.

A rename table records, for every register with a write still in flight, the tag of its newest producer. The lookup port uses that table to return either the committed register value or the value held in the buffer. When the producer has not finished yet, the lookup reports the value as not ready.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, `ret_valid` and `flush_valid` are 0, and every register looks up as not pending, ready, with value 0.
- R2: Accepted allocations receive tags 0, 1, 2, … in order. After DEPTH-1 the tag wraps to 0.
- R3: With DEPTH slots occupied, `alloc_ready` is 0 and an `alloc_req` has no effect on tags, on the rename table or on retirement.
- R4: A completion writes done, exception flag, value, store address and store data into the slot named by `cmp_tag`, in any order. A completion to a tag that holds no instruction is ignored.
- R5: At most one slot leaves per cycle, always the oldest, and only once it is done. An instruction whose older neighbour is not done does not retire even if it is done itself.
- R6: A retiring slot drives `ret_pc` and its kind. For a register write it also drives `ret_wr_reg`=1, `ret_reg` and `ret_value`, and updates the register file. For a store it drives `ret_store`=1, `ret_st_addr` and `ret_st_data`. An instruction with neither writes nothing.
- R7: A register with a write in flight looks up as pending, with the tag of its newest producer. It reports ready=0 until that producer completes, and then ready=1 with the buffered value.
- R8: When the oldest done slot carries an exception, the block raises `flush_valid` for one cycle, with `flush_exc_pc` set to that slot's PC and `flush_target` set to HANDLER_PC. It does not retire or write that slot. In the next cycle the buffer is empty, tags restart at 0 and no register is pending.
- R9: When a register write retires, the register stays pending if a younger in-flight instruction also writes it. It is released only if the retiring slot is still its newest producer.
- R10: An exception in a slot that is not the oldest causes no flush until all older slots have retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Decode requests a slot |
| alloc_wr_reg | input | 1 | Instruction writes a register |
| alloc_reg | input | REG_W | Destination register |
| alloc_store | input | 1 | Instruction is a store |
| alloc_pc | input | PC_W | Instruction PC |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W | Tag given to the request |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | TAG_W | Slot being completed |
| cmp_value | input | DATA_W | Register result |
| cmp_st_addr | input | ADDR_W | Store address |
| cmp_st_data | input | DATA_W | Store data |
| cmp_exc | input | 1 | Instruction raised an exception |
| lk_reg | input | REG_W | Register to look up |
| lk_pending | output | 1 | Register has a write in flight |
| lk_tag | output | TAG_W | Newest producer tag when pending |
| lk_ready | output | 1 | `lk_value` is usable |
| lk_value | output | DATA_W | Committed or buffered value |
| ret_valid | output | 1 | Oldest slot retires |
| ret_wr_reg | output | 1 | Retiring slot writes a register |
| ret_reg | output | REG_W | Register written |
| ret_value | output | DATA_W | Value written |
| ret_store | output | 1 | Retiring slot is a store |
| ret_st_addr | output | ADDR_W | Store address |
| ret_st_data | output | DATA_W | Store data |
| ret_pc | output | PC_W | PC of retiring slot |
| flush_valid | output | 1 | Exception at the oldest slot, all work dropped |
| flush_exc_pc | output | PC_W | PC of the faulting instruction |
| flush_target | output | PC_W | Fetch restart address |

## Verification
The main stimulus is a fixed twelve-instruction program that mixes register writes, stores and no-result instructions. It is completed in a scrambled order and checked against a sequential model of retirement order and register contents.

The first batch exactly fills the buffer and repeats a destination register. It therefore separates a correct newest-producer rename from one that is stale or cleared too early, and a correct full stall from an overrun. The second batch places an exception behind two writers of the same register and completes it first. It therefore distinguishes waiting for the head from flushing early, and shows that younger results are dropped while older ones commit.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Per-slot state flags
  typedef struct packed {
    logic valid;   // slot holds an instruction
    logic done;    // result posted
    logic exc;     // result carries an exception
    logic wr_reg;  // writes a register
    logic store;   // is a store
  } rob_flags_t;

  function automatic logic slot_commits(input rob_flags_t f);
    return f.valid & f.done & ~f.exc;
  endfunction

  function automatic logic slot_faults(input rob_flags_t f);
    return f.valid & f.done & f.exc;
  endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_alloc,
  input  logic             do_retire,
  input  logic             do_flush,
  output logic [TAG_W-1:0] head_q,
  output logic [TAG_W-1:0] tail_q,
  output logic [CNT_W-1:0] cnt_q
);

  // DEPTH is a power of two, so the pointer wraps by overflow
  function automatic logic [TAG_W-1:0] ptr_step(input logic [TAG_W-1:0] p);
    return p + TAG_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    return c + CNT_W'(up) - CNT_W'(dn);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (do_flush) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_retire) head_q <= ptr_step(head_q);
      if (do_alloc)  tail_q <= ptr_step(tail_q);
      cnt_q <= cnt_next(cnt_q, do_alloc, do_retire);
    end
  end

endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  // allocation
  input  logic              alloc_we,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              alloc_wr_reg,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic              alloc_store,
  input  logic [PC_W-1:0]   alloc_pc,
  // completion
  input  logic              cmp_we,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic [ADDR_W-1:0] cmp_st_addr,
  input  logic [DATA_W-1:0] cmp_st_data,
  input  logic              cmp_exc,
  // retirement
  input  logic              ret_we,
  // head read port
  input  logic [TAG_W-1:0]  hd_tag,
  output rob_flags_t        hd_flags,
  output logic [REG_W-1:0]  hd_reg,
  output logic [DATA_W-1:0] hd_value,
  output logic [ADDR_W-1:0] hd_st_addr,
  output logic [DATA_W-1:0] hd_st_data,
  output logic [PC_W-1:0]   hd_pc,
  // lookup read port
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_done,
  output logic [DATA_W-1:0] lk_value
);

  rob_flags_t        flg_v  [DEPTH];
  logic [REG_W-1:0]  reg_v  [DEPTH];
  logic [DATA_W-1:0] val_v  [DEPTH];
  logic [ADDR_W-1:0] addr_v [DEPTH];
  logic [DATA_W-1:0] sdat_v [DEPTH];
  logic [PC_W-1:0]   pc_v   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rob_flags_t        f_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] val_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] sdat_q;
    logic [PC_W-1:0]   pc_q;
    logic alloc_hit, cmp_hit, ret_hit;

    assign alloc_hit = alloc_we && (alloc_tag == TAG_W'(g));
    assign cmp_hit   = cmp_we && (cmp_tag == TAG_W'(g)) && f_q.valid;
    assign ret_hit   = ret_we && (hd_tag == TAG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q    <= '0;
        reg_q  <= '0;
        val_q  <= '0;
        addr_q <= '0;
        sdat_q <= '0;
        pc_q   <= '0;
      end else if (flush) begin
        f_q <= '0;
      end else begin
        if (ret_hit) f_q.valid <= 1'b0;
        if (alloc_hit) begin
          f_q    <= '{valid: 1'b1, done: 1'b0, exc: 1'b0,
                      wr_reg: alloc_wr_reg, store: alloc_store};
          reg_q  <= alloc_reg;
          pc_q   <= alloc_pc;
          val_q  <= '0;
          addr_q <= '0;
          sdat_q <= '0;
        end
        if (cmp_hit) begin
          f_q.done <= 1'b1;
          f_q.exc  <= cmp_exc;
          val_q    <= cmp_value;
          addr_q   <= cmp_st_addr;
          sdat_q   <= cmp_st_data;
        end
      end
    end

    assign flg_v[g]  = f_q;
    assign reg_v[g]  = reg_q;
    assign val_v[g]  = val_q;
    assign addr_v[g] = addr_q;
    assign sdat_v[g] = sdat_q;
    assign pc_v[g]   = pc_q;
  end

  assign hd_flags   = flg_v[hd_tag];
  assign hd_reg     = reg_v[hd_tag];
  assign hd_value   = val_v[hd_tag];
  assign hd_st_addr = addr_v[hd_tag];
  assign hd_st_data = sdat_v[hd_tag];
  assign hd_pc      = pc_v[hd_tag];

  assign lk_done  = flg_v[lk_tag].done;
  assign lk_value = val_v[lk_tag];

endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int NUM_REGS = 16,
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 32,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int TAG_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  // newest producer claim
  input  logic              ren_we,
  input  logic [REG_W-1:0]  ren_reg,
  input  logic [TAG_W-1:0]  ren_tag,
  // commit write
  input  logic              wb_we,
  input  logic [REG_W-1:0]  wb_reg,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_value,
  // lookup
  input  logic [REG_W-1:0]  lk_reg,
  output logic              lk_renamed,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [DATA_W-1:0] lk_arch
);

  logic              rv_v  [NUM_REGS];
  logic [TAG_W-1:0]  rt_v  [NUM_REGS];
  logic [DATA_W-1:0] arch_v[NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic              rv_q;
    logic [TAG_W-1:0]  rt_q;
    logic [DATA_W-1:0] arch_q;
    logic claim, commit, release_hit;

    assign claim       = ren_we && (ren_reg == REG_W'(r));
    assign commit      = wb_we && (wb_reg == REG_W'(r));
    assign release_hit = commit && rv_q && (rt_q == wb_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rv_q   <= 1'b0;
        rt_q   <= '0;
        arch_q <= '0;
      end else begin
        if (commit) arch_q <= wb_value;
        if (flush) begin
          rv_q <= 1'b0;
        end else if (claim) begin
          rv_q <= 1'b1;
          rt_q <= ren_tag;
        end else if (release_hit) begin
          rv_q <= 1'b0;
        end
      end
    end

    assign rv_v[r]   = rv_q;
    assign rt_v[r]   = rt_q;
    assign arch_v[r] = arch_q;
  end

  assign lk_renamed = rv_v[lk_reg];
  assign lk_tag     = rt_v[lk_reg];
  assign lk_arch    = arch_v[lk_reg];

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int               DEPTH      = 8,
  parameter int               NUM_REGS   = 16,
  parameter int               DATA_W     = 32,
  parameter int               ADDR_W     = 32,
  parameter int               PC_W       = 32,
  parameter logic [PC_W-1:0]  HANDLER_PC = 32'h0000_0180,
  localparam int              TAG_W      = $clog2(DEPTH),
  localparam int              CNT_W      = $clog2(DEPTH + 1),
  localparam int              REG_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic              alloc_wr_reg,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic              alloc_store,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic [ADDR_W-1:0] cmp_st_addr,
  input  logic [DATA_W-1:0] cmp_st_data,
  input  logic              cmp_exc,
  input  logic [REG_W-1:0]  lk_reg,
  output logic              lk_pending,
  output logic [TAG_W-1:0]  lk_tag,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_value,
  output logic              ret_valid,
  output logic              ret_wr_reg,
  output logic [REG_W-1:0]  ret_reg,
  output logic [DATA_W-1:0] ret_value,
  output logic              ret_store,
  output logic [ADDR_W-1:0] ret_st_addr,
  output logic [DATA_W-1:0] ret_st_data,
  output logic [PC_W-1:0]   ret_pc,
  output logic              flush_valid,
  output logic [PC_W-1:0]   flush_exc_pc,
  output logic [PC_W-1:0]   flush_target
);

  // Named internal events
  logic [TAG_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              buf_full;
  logic              do_alloc, do_retire, do_flush;
  rob_flags_t        hd_flags;
  logic [REG_W-1:0]  hd_reg;
  logic [DATA_W-1:0] hd_value, hd_st_data;
  logic [ADDR_W-1:0] hd_st_addr;
  logic [PC_W-1:0]   hd_pc;
  logic              ren_hit;
  logic [TAG_W-1:0]  ren_tag;
  logic [DATA_W-1:0] arch_val, buf_val;
  logic              buf_done;

  function automatic logic [DATA_W-1:0] pick_value(input logic renamed, input logic done,
                                                   input logic [DATA_W-1:0] arch,
                                                   input logic [DATA_W-1:0] buffered);
    if (!renamed) return arch;
    return done ? buffered : '0;
  endfunction

  assign buf_full  = (cnt_q == CNT_W'(DEPTH));
  assign do_retire = slot_commits(hd_flags);
  assign do_flush  = slot_faults(hd_flags);
  assign alloc_ready = !buf_full && !do_flush;
  assign do_alloc  = alloc_req && alloc_ready;
  assign alloc_tag = tail_q;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_alloc  (do_alloc),
    .do_retire (do_retire),
    .do_flush  (do_flush),
    .head_q    (head_q),
    .tail_q    (tail_q),
    .cnt_q     (cnt_q)
  );

  rob_entries #(
    .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_W(PC_W)
  ) u_entries (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (do_flush),
    .alloc_we     (do_alloc),
    .alloc_tag    (tail_q),
    .alloc_wr_reg (alloc_wr_reg),
    .alloc_reg    (alloc_reg),
    .alloc_store  (alloc_store),
    .alloc_pc     (alloc_pc),
    .cmp_we       (cmp_valid),
    .cmp_tag      (cmp_tag),
    .cmp_value    (cmp_value),
    .cmp_st_addr  (cmp_st_addr),
    .cmp_st_data  (cmp_st_data),
    .cmp_exc      (cmp_exc),
    .ret_we       (do_retire),
    .hd_tag       (head_q),
    .hd_flags     (hd_flags),
    .hd_reg       (hd_reg),
    .hd_value     (hd_value),
    .hd_st_addr   (hd_st_addr),
    .hd_st_data   (hd_st_data),
    .hd_pc        (hd_pc),
    .lk_tag       (ren_tag),
    .lk_done      (buf_done),
    .lk_value     (buf_val)
  );

  rob_rename #(.NUM_REGS(NUM_REGS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_rename (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (do_flush),
    .ren_we     (do_alloc && alloc_wr_reg),
    .ren_reg    (alloc_reg),
    .ren_tag    (tail_q),
    .wb_we      (do_retire && hd_flags.wr_reg),
    .wb_reg     (hd_reg),
    .wb_tag     (head_q),
    .wb_value   (hd_value),
    .lk_reg     (lk_reg),
    .lk_renamed (ren_hit),
    .lk_tag     (ren_tag),
    .lk_arch    (arch_val)
  );

  assign lk_pending = ren_hit;
  assign lk_tag     = ren_tag;
  assign lk_ready   = !ren_hit || buf_done;
  assign lk_value   = pick_value(ren_hit, buf_done, arch_val, buf_val);

  assign ret_valid    = do_retire;
  assign ret_wr_reg   = do_retire && hd_flags.wr_reg;
  assign ret_store    = do_retire && hd_flags.store;
  assign ret_reg      = hd_reg;
  assign ret_value    = hd_value;
  assign ret_st_addr  = hd_st_addr;
  assign ret_st_data  = hd_st_data;
  assign ret_pc       = hd_pc;

  assign flush_valid  = do_flush;
  assign flush_exc_pc = hd_pc;
  assign flush_target = HANDLER_PC;

endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAG_W-1:0] head_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             do_retire,
  input logic             do_flush,
  input logic             alloc_req,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             ret_valid,
  input logic             flush_valid
);

  // R2
  tag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_ready) |=> alloc_tag == TAG_W'($past(alloc_tag) + 1'b1));

  // R3
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R3
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH) && !do_retire && !do_flush) |=> cnt_q == CNT_W'(DEPTH));

  // R5
  head_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> head_q == TAG_W'($past(head_q) + 1'b1));

  // R5
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (!ret_valid && !flush_valid));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (cnt_q == '0 && alloc_tag == '0 && !ret_valid && !flush_valid));

endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .head_q      (head_q),
  .cnt_q       (cnt_q),
  .do_retire   (do_retire),
  .do_flush    (do_flush),
  .alloc_req   (alloc_req),
  .alloc_ready (alloc_ready),
  .alloc_tag   (alloc_tag),
  .ret_valid   (ret_valid),
  .flush_valid (flush_valid)
);

// File: tb/reorder_buf_tb.sv
module reorder_buf_tb_top;

  localparam int DEPTH = 8;
  localparam int NREG  = 16;
  localparam int TAG_W = 3;
  localparam int REG_W = 4;
  localparam logic [31:0] HANDLER = 32'h0000_0180;
  localparam int NPROG = 12;

  // Program table: {kind[6:5], dest[4:1], exc[0]}; kind 0=reg write, 1=store, 2=no result
  localparam logic [6:0] PROG [NPROG] = '{
    7'b0000010, 7'b0000100, 7'b0100000, 7'b0000010,
    7'b1000000, 7'b0001110, 7'b0100000, 7'b0011110,
    7'b0001010, 7'b0001010, 7'b0010011, 7'b0000100
  };
  // Completion order of the first batch (program indices)
  localparam int ORD_A [8] = '{3, 6, 1, 0, 7, 2, 5, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              alloc_req = 0, alloc_wr_reg = 0, alloc_store = 0;
  logic [REG_W-1:0]  alloc_reg = 0;
  logic [31:0]       alloc_pc = 0;
  logic              alloc_ready;
  logic [TAG_W-1:0]  alloc_tag;
  logic              cmp_valid = 0, cmp_exc = 0;
  logic [TAG_W-1:0]  cmp_tag = 0;
  logic [31:0]       cmp_value = 0, cmp_st_addr = 0, cmp_st_data = 0;
  logic [REG_W-1:0]  lk_reg = 0;
  logic              lk_pending, lk_ready;
  logic [TAG_W-1:0]  lk_tag;
  logic [31:0]       lk_value;
  logic              ret_valid, ret_wr_reg, ret_store;
  logic [REG_W-1:0]  ret_reg;
  logic [31:0]       ret_value, ret_st_addr, ret_st_data, ret_pc;
  logic              flush_valid;
  logic [31:0]       flush_exc_pc, flush_target;

  reorder_buf dut_i (.*);

  int n_tests = 0, n_fail = 0;
  int exp_idx = 0, flush_seen = 0, cyc = 0;
  logic [31:0] arch_exp [NREG];

  function automatic logic [1:0] kind_of(int i); return PROG[i][6:5]; endfunction
  function automatic logic [3:0] dest_of(int i); return PROG[i][4:1]; endfunction
  function automatic logic       exc_of(int i);  return PROG[i][0];   endfunction
  function automatic logic [31:0] pc_of(int i);  return 32'h1000 + 32'(i) * 4; endfunction
  function automatic logic [31:0] val_of(int i); return 32'hA000_0000 + 32'(i) * 32'h11; endfunction
  function automatic logic [31:0] adr_of(int i); return 32'h2000 + 32'(i) * 8; endfunction
  function automatic logic [31:0] sd_of(int i);  return val_of(i) ^ 32'h0000_FFFF; endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model_apply(input int lo, input int hi);
    for (int i = lo; i < hi; i++)
      if (kind_of(i) == 2'd0 && !exc_of(i)) arch_exp[dest_of(i)] = val_of(i);
  endtask

  task automatic alloc_one(input int i, input logic [TAG_W-1:0] etag, input string req);
    alloc_req    = 1'b1;
    alloc_wr_reg = (kind_of(i) == 2'd0);
    alloc_store  = (kind_of(i) == 2'd1);
    alloc_reg    = dest_of(i);
    alloc_pc     = pc_of(i);
    #1;
    chk(alloc_ready == 1'b1, req, 32'(alloc_ready), 32'd1);
    chk(alloc_tag == etag, req, 32'(alloc_tag), 32'(etag));
    @(negedge clk);
    alloc_req = 1'b0;
  endtask

  task automatic cmp_one(input int i, input logic [TAG_W-1:0] tag);
    cmp_valid   = 1'b1;
    cmp_tag     = tag;
    cmp_value   = val_of(i);
    cmp_st_addr = adr_of(i);
    cmp_st_data = sd_of(i);
    cmp_exc     = exc_of(i);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic lk_chk(input logic [3:0] r, input logic pend, input logic rdy,
                        input logic [31:0] v, input string req);
    lk_reg = r;
    #1;
    chk(lk_pending == pend, req, 32'(lk_pending), 32'(pend));
    chk(lk_ready == rdy, req, 32'(lk_ready), 32'(rdy));
    if (rdy) chk(lk_value == v, req, lk_value, v);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Retirement and flush monitor against the sequential program order
  always @(negedge clk) begin
    if (rst_n) begin
      if (ret_valid) begin
        if (exp_idx >= NPROG || exc_of(exp_idx)) begin
          chk(1'b0, "R5 unexpected retire", ret_pc, 32'd0);
        end else begin
          chk(ret_pc == pc_of(exp_idx), "R5 retire order", ret_pc, pc_of(exp_idx));
          chk(ret_wr_reg == (kind_of(exp_idx) == 2'd0), "R6 reg kind", 32'(ret_wr_reg), 32'(kind_of(exp_idx) == 2'd0));
          chk(ret_store == (kind_of(exp_idx) == 2'd1), "R6 store kind", 32'(ret_store), 32'(kind_of(exp_idx) == 2'd1));
          if (kind_of(exp_idx) == 2'd0) begin
            chk(ret_reg == dest_of(exp_idx), "R6 reg id", 32'(ret_reg), 32'(dest_of(exp_idx)));
            chk(ret_value == val_of(exp_idx), "R6 reg value", ret_value, val_of(exp_idx));
          end
          if (kind_of(exp_idx) == 2'd1) begin
            chk(ret_st_addr == adr_of(exp_idx), "R6 store addr", ret_st_addr, adr_of(exp_idx));
            chk(ret_st_data == sd_of(exp_idx), "R6 store data", ret_st_data, sd_of(exp_idx));
          end
          exp_idx++;
        end
      end
      if (flush_valid) begin
        chk(exp_idx < NPROG && exc_of(exp_idx), "R8 flush timing", 32'(exp_idx), 32'd10);
        chk(flush_exc_pc == pc_of(10), "R8 exc pc", flush_exc_pc, pc_of(10));
        chk(flush_target == HANDLER, "R8 target", flush_target, HANDLER);
        exp_idx = NPROG;
        flush_seen++;
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) arch_exp[r] = '0;
    idle(3);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(alloc_ready == 1'b1, "R1 ready", 32'(alloc_ready), 32'd1);
    chk(alloc_tag == '0, "R1 tag", 32'(alloc_tag), 32'd0);
    chk(!ret_valid && !flush_valid, "R1 quiet", 32'({ret_valid, flush_valid}), 32'd0);
    lk_chk(4'd3, 1'b0, 1'b1, 32'd0, "R1 lookup");

    // First batch from the table: fills the buffer exactly
    for (int i = 0; i < DEPTH; i++) alloc_one(i, TAG_W'(i), "R2 alloc tag");
    #1;
    chk(alloc_ready == 1'b0, "R3 full", 32'(alloc_ready), 32'd0);
    // R7 newest writer of r1 is program 3, not done
    lk_chk(4'd1, 1'b1, 1'b0, 32'd0, "R7 pending");
    chk(lk_tag == 3'd3, "R7 newest tag", 32'(lk_tag), 32'd3);
    // R3 requests while full are dropped
    alloc_req = 1'b1; alloc_wr_reg = 1'b1; alloc_reg = 4'd2; alloc_pc = 32'hDEAD;
    idle(2);
    alloc_req = 1'b0;

    for (int k = 0; k < DEPTH; k++) begin
      cmp_one(ORD_A[k], TAG_W'(ORD_A[k]));
      if (k == 0) begin
        #1;
        // R5 done but not oldest: no retire
        chk(ret_valid == 1'b0, "R5 wait head", 32'(ret_valid), 32'd0);
        // R4 out of order result visible via buffer, R7 ready
        lk_chk(4'd1, 1'b1, 1'b1, val_of(3), "R7 buffered value");
      end
      if (k == 3) begin
        idle(2);
        // R9 program 0 retired but r1 still owned by program 3
        lk_chk(4'd1, 1'b1, 1'b1, val_of(3), "R9 pointer kept");
      end
    end
    idle(10);
    chk(exp_idx == 8, "R5 all retired", 32'(exp_idx), 32'd8);
    #1;
    chk(alloc_ready == 1'b1, "R3 ready again", 32'(alloc_ready), 32'd1);
    chk(alloc_tag == '0, "R2 wrap", 32'(alloc_tag), 32'd0);
    model_apply(0, 8);
    for (int r = 0; r < NREG; r++) lk_chk(4'(r), 1'b0, 1'b1, arch_exp[r], "R6 arch state");

    // R4 completion to an empty slot is ignored
    cmp_valid = 1'b1; cmp_tag = 3'd2; cmp_exc = 1'b1; cmp_value = 32'hBAD0;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_exc = 1'b0;
    idle(3);
    chk(!ret_valid && !flush_valid, "R4 stray completion", 32'({ret_valid, flush_valid}), 32'd0);
    lk_chk(4'd2, 1'b0, 1'b1, arch_exp[2], "R4 state untouched");

    // Second batch: exception behind two writers of r5
    for (int i = 8; i < NPROG; i++) alloc_one(i, TAG_W'(i - 8), "R2 alloc tag b");
    lk_chk(4'd5, 1'b1, 1'b0, 32'd0, "R7 pending b");
    chk(lk_tag == 3'd1, "R7 newest tag b", 32'(lk_tag), 32'd1);
    cmp_one(10, 3'd2);
    idle(2);
    chk(flush_valid == 1'b0 && flush_seen == 0, "R10 no early flush", 32'(flush_seen), 32'd0);
    cmp_one(8, 3'd0);
    idle(2);
    lk_chk(4'd5, 1'b1, 1'b0, 32'd0, "R9 younger writer pending");
    chk(lk_tag == 3'd1, "R9 pointer tag", 32'(lk_tag), 32'd1);
    cmp_one(11, 3'd3);
    cmp_one(9, 3'd1);
    idle(6);
    chk(flush_seen == 1, "R8 one flush", 32'(flush_seen), 32'd1);
    model_apply(8, 10);
    for (int r = 0; r < NREG; r++) lk_chk(4'(r), 1'b0, 1'b1, arch_exp[r], "R8 state after flush");
    #1;
    chk(alloc_tag == '0, "R8 tag restart", 32'(alloc_tag), 32'd0);
    chk(alloc_ready == 1'b1, "R8 ready", 32'(alloc_ready), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule